// File: doc/BRIEF.md
# Maskable Edge-Captured Interrupt Controller

This block gathers a set of interrupt request lines (twelve by default, in three groups of four) into request flags, and drives one interrupt line to the processor. Each line has its own mask bit. A flag is captured on a rising edge of its line, and only while that line is unmasked. The interrupt output is asserted when any flag is set and a global enable bit is on. The block has no hardware priority: software reads the flag registers and chooses which request to service first.

Software reaches the flags, masks and enable through a small register bus. It has an address, write data, a write strobe, a read strobe and combinational read data. Reading a flag register returns the current flags of that group and clears them in the same cycle. A single flag can also be cleared by writing 1 to its bit. A new edge that lands in the same cycle as a clear keeps its flag set, so a request that arrives during service is never lost.

Top module: `irq_capture_ctrl`

## Requirements
- R1: After reset all masks, the enable bit and all flags are 0, and `irq` is 0.
- R2: A rising edge on source line i while its mask bit is 1 sets flag i at that clock edge. Flag i is bit (i mod 4) of the flag register at address i/4 (addresses 0, 1, 2).
- R3: A rising edge on a masked line stores nothing. Setting the mask later, with no new edge, leaves the flag at 0.
- R4: A source held high produces only one capture. After that flag is cleared it stays 0 until the line falls and rises again.
- R5: `irq` equals the OR of all flags ANDed with the enable bit, which is bit 0 of the control register at address 3.
- R6: A read of flag address g returns that group's flags as they stood before the read, and clears every flag of group g at that edge. Other groups are untouched.
- R7: A write to flag address g clears each flag whose write-data bit is 1. Bits written 0 are unchanged.
- R8: A rising edge on an unmasked line in the same cycle as a read-clear or write-1-clear of its flag leaves the flag set.
- R9: The mask registers of groups 0, 1 and 2 are at addresses 4, 5 and 6, and read back what was written. The control register reads back its enable bit. A read of address 7 returns 0.
- R10: A flag captured while other flags are pending keeps `irq` high after those other flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 12 | Interrupt request lines, synchronous to clk |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 4 | Write data |
| bus_rd_en | input | 1 | Read strobe; clears the addressed flag group |
| bus_rd_data | output | 4 | Combinational read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A flag stuck at 1 keeps `irq` high one cycle after the enable is set, and shows in the next read of its group. A flag lost at capture shows as a zero read one cycle after the edge. A wrong previous-level register in the edge detector either repeats a capture while a line is held high or misses a capture. The next read of that group shows either fault. Clear logic that is wrongly scoped or ordered shows on the read after a clear, in the cleared group, in a neighbouring group, or on a flag whose edge coincided with the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_FLAG,
        SEL_CTRL,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic en;
    } ctrl_t;
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_SRC-1:0] rise
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev = src_in;
        rise      = src_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_group.sv
module irq_group #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise,
    input  logic             rd_clr,
    input  logic             wr_flag,
    input  logic             wr_mask,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] flags,
    output logic [LINES-1:0] mask
);
    typedef struct packed {
        logic [LINES-1:0] flags;
        logic [LINES-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [LINES-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (rd_clr)  clr = '1;
        if (wr_flag) clr = clr | wr_data;
        // a capture in the same cycle overrides any clear
        st_d.flags = (st_q.flags & ~clr) | (rise & st_q.mask);
        if (wr_mask) st_d.mask = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign mask  = st_q.mask;
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl #(
    parameter int NUM_GROUPS = 3,
    parameter int LINES      = 4,
    parameter int ADDR_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*LINES-1:0] src_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr_en,
    input  logic [LINES-1:0]            bus_wr_data,
    input  logic                        bus_rd_en,
    output logic [LINES-1:0]            bus_rd_data,
    output logic                        irq
);
    import irq_pkg::*;

    localparam int NUM_SRC   = NUM_GROUPS * LINES;
    localparam int CTRL_ADDR = NUM_GROUPS;
    localparam int MASK_BASE = NUM_GROUPS + 1;

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] flags_all;
    logic [NUM_SRC-1:0] mask_all;
    ctrl_t              ctrl_d, ctrl_q;
    reg_sel_e           sel;
    int                 sel_idx;

    irq_edge_sense #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .rise   (rise)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic rd_clr, wr_flag, wr_mask;
        assign rd_clr  = bus_rd_en && (bus_addr == ADDR_W'(g));
        assign wr_flag = bus_wr_en && (bus_addr == ADDR_W'(g));
        assign wr_mask = bus_wr_en && (bus_addr == ADDR_W'(MASK_BASE + g));
        irq_group #(.LINES(LINES)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise[g*LINES +: LINES]),
            .rd_clr  (rd_clr),
            .wr_flag (wr_flag),
            .wr_mask (wr_mask),
            .wr_data (bus_wr_data),
            .flags   (flags_all[g*LINES +: LINES]),
            .mask    (mask_all[g*LINES +: LINES])
        );
    end

    always_comb begin
        sel     = SEL_NONE;
        sel_idx = 0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(g)) begin
                sel     = SEL_FLAG;
                sel_idx = g;
            end
            if (bus_addr == ADDR_W'(MASK_BASE + g)) begin
                sel     = SEL_MASK;
                sel_idx = g;
            end
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr_en && sel == SEL_CTRL) ctrl_d.en = bus_wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        bus_rd_data = '0;
        case (sel)
            SEL_FLAG: bus_rd_data = flags_all[sel_idx*LINES +: LINES];
            SEL_MASK: bus_rd_data = mask_all[sel_idx*LINES +: LINES];
            SEL_CTRL: bus_rd_data = LINES'(ctrl_q.en);
            default:  bus_rd_data = '0;
        endcase
    end

    assign irq = ctrl_q.en && (|flags_all);
endmodule

// File: rtl/irq_capture_ctrl_chk.sv
module irq_capture_ctrl_chk #(
    parameter int NUM_GROUPS = 3,
    parameter int LINES      = 4,
    parameter int ADDR_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr_en,
    input logic                        bus_rd_en,
    input logic [LINES-1:0]            bus_wr_data,
    input logic                        irq,
    input logic [NUM_GROUPS*LINES-1:0] rise,
    input logic [NUM_GROUPS*LINES-1:0] mask_all,
    input logic [NUM_GROUPS*LINES-1:0] flags_all,
    input irq_pkg::ctrl_t              ctrl_q
);
    localparam int NUM_SRC = NUM_GROUPS * LINES;

    logic [NUM_SRC-1:0] rd_sel, w1c_sel, capt;

    always_comb begin
        rd_sel  = '0;
        w1c_sel = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(g)) begin
                if (bus_rd_en) rd_sel[g*LINES +: LINES] = '1;
                if (bus_wr_en) w1c_sel[g*LINES +: LINES] = bus_wr_data;
            end
        end
        capt = rise & mask_all;
    end

    p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q.en);

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags_all));

    p_masked_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_all & ~$past(flags_all) & ~$past(mask_all)) == '0));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> ((flags_all & $past(rd_sel) & ~$past(capt)) == '0));

    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |=> ((flags_all & $past(w1c_sel) & ~$past(capt)) == '0));

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|capt) |=> (($past(capt) & ~flags_all) == '0));
endmodule

bind irq_capture_ctrl irq_capture_ctrl_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .LINES      (LINES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_rd_en   (bus_rd_en),
    .bus_wr_data (bus_wr_data),
    .irq         (irq),
    .rise        (rise),
    .mask_all    (mask_all),
    .flags_all   (flags_all),
    .ctrl_q      (ctrl_q)
);

// File: tb/tb_irq_capture_ctrl.sv
module tb_irq_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [3:0]  bus_rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [3:0]  rv;

    irq_capture_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
        .bus_rd_data(bus_rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        step();
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        #5 d = bus_rd_data;
        step();
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse(input int i);
        src_in[i] = 1'b1;
        step();
        src_in[i] = 1'b0;
        step();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #35 rst_n = 1'b1;
        step();
        // R1: reset state
        check("R1 irq", int'(irq), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), rv);
            check("R1 reg", int'(rv), 0);
        end
        // R3: edges while masked are dropped
        for (int i = 0; i < 12; i++) pulse(i);
        wr(3'd3, 4'h1);
        for (int g = 0; g < 3; g++) wr(3'(4 + g), 4'hF);
        for (int g = 0; g < 3; g++) begin
            rd(3'(g), rv);
            check("R3 masked", int'(rv), 0);
        end
        check("R3 irq", int'(irq), 0);
        // R2/R5/R6: sweep every line
        for (int i = 0; i < 12; i++) begin
            pulse(i);
            check("R5 irq set", int'(irq), 1);
            for (int g = 0; g < 3; g++) begin
                rd(3'(g), rv);
                check("R2 R6 flags", int'(rv), (g == i / 4) ? (1 << (i % 4)) : 0);
            end
            check("R6 cleared irq", int'(irq), 0);
        end
        // R5: enable gates output
        wr(3'd3, 4'h0);
        pulse(7);
        check("R5 disabled", int'(irq), 0);
        wr(3'd3, 4'h1);
        check("R5 enabled", int'(irq), 1);
        rd(3'd1, rv);
        check("R5 flag", int'(rv), 4'h8);
        // R4: held level captures once
        src_in[2] = 1'b1;
        step(); step();
        rd(3'd0, rv);
        check("R4 first", int'(rv), 4'h4);
        step(); step(); step();
        rd(3'd0, rv);
        check("R4 held", int'(rv), 0);
        src_in[2] = 1'b0;
        step();
        // R7: write-1 clears single bits
        pulse(4); pulse(5);
        wr(3'd1, 4'h0);
        wr(3'd1, 4'h1);
        rd(3'd1, rv);
        check("R7 w1c", int'(rv), 4'h2);
        // R8: edge coincident with read-clear
        src_in[0] = 1'b1;
        rd(3'd0, rv);
        check("R8 pre", int'(rv), 0);
        src_in[0] = 1'b0;
        rd(3'd0, rv);
        check("R8 rd edge wins", int'(rv), 4'h1);
        // R8: edge coincident with write-1-clear
        pulse(9);
        src_in[9] = 1'b1;
        wr(3'd2, 4'h2);
        src_in[9] = 1'b0;
        rd(3'd2, rv);
        check("R8 w1c edge wins", int'(rv), 4'h2);
        // R10: pending request survives service of another
        pulse(1); pulse(11);
        rd(3'd0, rv);
        check("R10 first", int'(rv), 4'h2);
        check("R10 irq still", int'(irq), 1);
        rd(3'd2, rv);
        check("R10 second", int'(rv), 4'h8);
        check("R10 irq done", int'(irq), 0);
        // R9: readback of masks, control, unmapped
        wr(3'd4, 4'h5); wr(3'd5, 4'hA); wr(3'd6, 4'h3);
        for (int g = 0; g < 3; g++) begin
            rd(3'(4 + g), rv);
            check("R9 mask", int'(rv), (g == 0) ? 5 : (g == 1) ? 10 : 3);
        end
        rd(3'd3, rv);
        check("R9 ctrl", int'(rv), 1);
        rd(3'd7, rv);
        check("R9 unmapped", int'(rv), 0);
        // R3: masked bit later unmasked stays empty
        pulse(1);
        wr(3'd4, 4'hF);
        rd(3'd0, rv);
        check("R3 late unmask", int'(rv), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule